// File: doc/BRIEF.md
# Ordered Reset Release Controller with Ready Handshakes

This block brings three downstream stages out of reset in a fixed order: a physical-layer stage first, then a link-layer stage, then a DMA stage. It runs on a single clock. An external active-low reset and a clock-generator lock flag are combined into one qualified reset. While that qualified reset is low, every hold output is driven low at once, with no clock edge needed. This still works when the clock is stopped or has not yet settled.

Once the qualified reset goes high, its rising edge passes through a two-flop synchronizer. A state machine then releases the physical-layer stage. It releases each later stage only after the stage before it reports ready and a minimum spacing between releases has passed. Each wait for a ready has a timeout. If the timeout expires, a sticky error flag is raised and the sequence halts with the remaining stages still held in reset. A completion flag and a count of released stages report progress.

Top module: `rstseq_top`

## Requirements
- R1: The qualified reset is `board_rst_n AND clk_locked`. While it is low, `phy_hold_n`, `link_hold_n` and `dma_hold_n` are all 0, `seq_done` is 0 and `stage_count` is 0. They stay that way as long as either input is low, for any number of cycles.
- R2: When the qualified reset falls, all three hold outputs, `seq_done`, `stage_count` and `timeout_err` drop to 0 immediately, without waiting for a clock edge.
- R3: After the qualified reset rises between clock edges, `phy_hold_n` goes to 1 on the fourth rising clock edge: two edges in the synchronizer and two in the sequencer.
- R4: The stages are released in a fixed order. `link_hold_n` is released only after `phy_ready` has been sampled high, and `dma_hold_n` only after `link_ready` has been sampled high. A stage that has been released stays released until the next qualified reset.
- R5: Take one release at edge t. The next stage is released one edge after the first edge t+k, with k ≥ 1, at which two things hold: its ready is high, and k ≥ MIN_GAP−1. If a ready is driven high right after edge t+d, the two releases are therefore max(MIN_GAP, d+2) edges apart.
- R6: Each ready input is looked at only while the sequencer is waiting for that stage. A `link_ready` that is high before the physical-layer stage is ready does not release the link-layer stage. A ready that is already high when its wait begins gives a spacing of exactly MIN_GAP.
- R7: Take a release at edge t. If no qualifying ready has been seen by edge t+TIMEOUT_CYCLES+1, `timeout_err` goes to 1 on that edge. A ready seen on that same edge still advances the sequence, and no error is raised.
- R8: Once `timeout_err` is 1, it stays 1 and no further stage is released, even if the ready arrives later. Only a qualified reset clears it.
- R9: `seq_done` is 1 exactly while `dma_hold_n` is 1. `stage_count` is the binary count (0 to 3) of hold outputs that have been released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| board_rst_n | input | 1 | External asynchronous reset, active low |
| clk_locked | input | 1 | Clock generator lock flag, high when stable |
| phy_ready | input | 1 | Physical-layer stage reports ready |
| link_ready | input | 1 | Link-layer stage reports ready |
| phy_hold_n | output | 1 | Physical-layer reset, active low |
| link_hold_n | output | 1 | Link-layer reset, active low |
| dma_hold_n | output | 1 | DMA reset, active low |
| seq_done | output | 1 | High once all three stages are released |
| stage_count | output | 2 | Number of stages released so far |
| timeout_err | output | 1 | Sticky flag set when a ready wait times out |

## Verification
The hardest conditions to reach are the timeout edge and a reset that arrives between clock edges. At the timeout edge, a ready must still win on the very cycle the counter runs out, and must lose if it comes one cycle later. The stimulus reaches the timeout edge by driving the physical-layer ready exactly TIMEOUT_CYCLES cycles after that stage is released, and then one cycle later in a separate run, with a short timeout parameter so both runs are brief. Asynchronous assertion is tested by dropping the lock flag partway through a clock phase, in the middle of a sequence. The outputs are checked before the next edge arrives.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int NUM_STAGES = 3;

    typedef enum logic [2:0] {
        ST_HOLD        = 3'd0,
        ST_FREE_PHY    = 3'd1,
        ST_AWAIT_PHY   = 3'd2,
        ST_FREE_LINK   = 3'd3,
        ST_AWAIT_LINK  = 3'd4,
        ST_FREE_DMA    = 3'd5,
        ST_RUN         = 3'd6
    } seq_state_e;

    // State in which stage idx is released
    function automatic seq_state_e free_state(input int idx);
        case (idx)
            0:       return ST_FREE_PHY;
            1:       return ST_FREE_LINK;
            default: return ST_FREE_DMA;
        endcase
    endfunction

    function automatic logic is_free(input seq_state_e s);
        return (s == ST_FREE_PHY) || (s == ST_FREE_LINK) || (s == ST_FREE_DMA);
    endfunction

    function automatic logic is_await(input seq_state_e s);
        return (s == ST_AWAIT_PHY) || (s == ST_AWAIT_LINK);
    endfunction

    function automatic logic [1:0] count_released(input logic [NUM_STAGES-1:0] rel);
        logic [1:0] n;
        n = 2'd0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            n = n + {1'b0, rel[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic sync_n
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int TIMEOUT_CYCLES = 1000,
    parameter int MIN_GAP        = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic load,
    input  logic run,
    output logic expired,
    output logic gap_met
);

    localparam int TW       = $clog2(TIMEOUT_CYCLES + 1);
    localparam int GW       = (MIN_GAP > 1) ? $clog2(MIN_GAP + 1) : 1;
    localparam int GAP_LOAD = (MIN_GAP > 2) ? MIN_GAP - 2 : 0;

    logic [TW-1:0] tmo_q;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            tmo_q <= '0;
            gap_q <= '0;
        end else if (load) begin
            tmo_q <= TW'(TIMEOUT_CYCLES);
            gap_q <= GW'(GAP_LOAD);
        end else if (run) begin
            if (tmo_q != '0) tmo_q <= tmo_q - TW'(1);
            if (gap_q != '0) gap_q <= gap_q - GW'(1);
        end
    end

    assign expired = (tmo_q == '0);
    assign gap_met = (gap_q == '0);

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  arst_n,
    input  logic                  sync_n,
    input  logic                  phy_ready,
    input  logic                  link_ready,
    input  logic                  expired,
    input  logic                  gap_met,
    output logic                  load,
    output logic                  run,
    output seq_state_e            state,
    output logic [NUM_STAGES-1:0] released,
    output logic                  fault
);

    seq_state_e state_q, state_d;
    logic       fault_q, fault_d;
    logic       rdy_sel;

    assign rdy_sel = (state_q == ST_AWAIT_PHY) ? phy_ready : link_ready;

    always_comb begin
        state_d = state_q;
        fault_d = fault_q;
        case (state_q)
            ST_HOLD:       if (sync_n) state_d = ST_FREE_PHY;
            ST_FREE_PHY:   state_d = ST_AWAIT_PHY;
            ST_FREE_LINK:  state_d = ST_AWAIT_LINK;
            ST_FREE_DMA:   state_d = ST_RUN;
            ST_AWAIT_PHY,
            ST_AWAIT_LINK: begin
                if (!fault_q) begin
                    if (rdy_sel && gap_met) begin
                        state_d = (state_q == ST_AWAIT_PHY) ? ST_FREE_LINK : ST_FREE_DMA;
                    end else if (expired) begin
                        fault_d = 1'b1;
                    end
                end
            end
            default:       state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_HOLD;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
        end
    end

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_release
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                released[g] <= 1'b0;
            end else if (state_q == free_state(g)) begin
                released[g] <= 1'b1;
            end
        end
    end

    assign load  = is_free(state_q);
    assign run   = is_await(state_q);
    assign state = state_q;
    assign fault = fault_q;

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000,
    parameter int MIN_GAP        = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       board_rst_n,
    input  logic       clk_locked,
    input  logic       phy_ready,
    input  logic       link_ready,
    output logic       phy_hold_n,
    output logic       link_hold_n,
    output logic       dma_hold_n,
    output logic       seq_done,
    output logic [1:0] stage_count,
    output logic       timeout_err
);

    logic                  qual_n;
    logic                  sync_n;
    logic                  load, run, expired, gap_met;
    seq_state_e            state;
    logic [NUM_STAGES-1:0] released;

    assign qual_n = board_rst_n & clk_locked;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (qual_n),
        .sync_n (sync_n)
    );

    rstseq_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .MIN_GAP(MIN_GAP)) u_timer (
        .clk     (clk),
        .arst_n  (qual_n),
        .load    (load),
        .run     (run),
        .expired (expired),
        .gap_met (gap_met)
    );

    rstseq_fsm u_fsm (
        .clk        (clk),
        .arst_n     (qual_n),
        .sync_n     (sync_n),
        .phy_ready  (phy_ready),
        .link_ready (link_ready),
        .expired    (expired),
        .gap_met    (gap_met),
        .load       (load),
        .run        (run),
        .state      (state),
        .released   (released),
        .fault      (timeout_err)
    );

    assign phy_hold_n  = released[0];
    assign link_hold_n = released[1];
    assign dma_hold_n  = released[2];
    assign seq_done    = (state == ST_RUN);
    assign stage_count = count_released(released);

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
    input logic       clk,
    input logic       qual_n,
    input logic       phy_ready,
    input logic       link_ready,
    input logic       phy_hold_n,
    input logic       link_hold_n,
    input logic       dma_hold_n,
    input logic       seq_done,
    input logic [1:0] stage_count,
    input logic       timeout_err
);

    // R1 and R2: everything held low while the qualified reset is low
    a_r1_held_low: assert property (@(posedge clk)
        !qual_n |-> (!phy_hold_n && !link_hold_n && !dma_hold_n && !seq_done
                     && stage_count == 2'd0 && !timeout_err));

    a_r3_first_release: assert property (@(posedge clk) disable iff (!qual_n)
        $rose(phy_hold_n) |-> $past(qual_n, 4));

    a_r4_link_after_phy: assert property (@(posedge clk) disable iff (!qual_n)
        link_hold_n |-> phy_hold_n);

    a_r4_dma_after_link: assert property (@(posedge clk) disable iff (!qual_n)
        dma_hold_n |-> link_hold_n);

    a_r4_link_needs_ready: assert property (@(posedge clk) disable iff (!qual_n)
        $rose(link_hold_n) |-> $past(phy_ready, 2));

    a_r4_dma_needs_ready: assert property (@(posedge clk) disable iff (!qual_n)
        $rose(dma_hold_n) |-> $past(link_ready, 2));

    a_r4_no_rehold: assert property (@(posedge clk) disable iff (!qual_n)
        phy_hold_n |=> phy_hold_n);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!qual_n)
        timeout_err |=> timeout_err);

    a_r8_frozen_after_err: assert property (@(posedge clk) disable iff (!qual_n)
        timeout_err |=> $stable({phy_hold_n, link_hold_n, dma_hold_n}));

    a_r9_done_tracks_dma: assert property (@(posedge clk) disable iff (!qual_n)
        seq_done == dma_hold_n);

    a_r9_count_matches: assert property (@(posedge clk) disable iff (!qual_n)
        32'(stage_count) == $countones({phy_hold_n, link_hold_n, dma_hold_n}));

endmodule

bind rstseq_top rstseq_chk u_chk (
    .clk         (clk),
    .qual_n      (qual_n),
    .phy_ready   (phy_ready),
    .link_ready  (link_ready),
    .phy_hold_n  (phy_hold_n),
    .link_hold_n (link_hold_n),
    .dma_hold_n  (dma_hold_n),
    .seq_done    (seq_done),
    .stage_count (stage_count),
    .timeout_err (timeout_err)
);

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;

    localparam int TMO = 20;
    localparam int GAP = 4;

    logic       clk = 1'b0;
    logic       board_rst_n = 1'b1;
    logic       clk_locked = 1'b1;
    logic       phy_ready = 1'b0;
    logic       link_ready = 1'b0;
    logic       phy_hold_n, link_hold_n, dma_hold_n, seq_done, timeout_err;
    logic [1:0] stage_count;

    always #4 clk = ~clk;

    rstseq_top #(.TIMEOUT_CYCLES(TMO), .MIN_GAP(GAP)) u_rstseq_top (
        .clk         (clk),
        .board_rst_n (board_rst_n),
        .clk_locked  (clk_locked),
        .phy_ready   (phy_ready),
        .link_ready  (link_ready),
        .phy_hold_n  (phy_hold_n),
        .link_hold_n (link_hold_n),
        .dma_hold_n  (dma_hold_n),
        .seq_done    (seq_done),
        .stage_count (stage_count),
        .timeout_err (timeout_err)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic hold_of(input int idx);
        case (idx)
            0:       return phy_hold_n;
            1:       return link_hold_n;
            default: return dma_hold_n;
        endcase
    endfunction

    task automatic wait_hold(input int idx, output int at);
        int lim;
        lim = 0;
        at = -1;
        while (at < 0) begin
            @(negedge clk);
            if (hold_of(idx)) at = cyc;
            else begin
                lim++;
                if (lim > 200) begin
                    chk("R4 release never seen", 0, 1);
                    at = cyc;
                end
            end
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        board_rst_n = 1'b0;
        clk_locked  = 1'b1;
        phy_ready   = 1'b0;
        link_ready  = 1'b0;
        repeat (3) @(negedge clk);
        board_rst_n = 1'b1;
    endtask

    typedef struct packed {
        int dp;
        int dl;
        int g1;
        int g2;
    } vec_t;

    // Ready delays after each release, and the release spacings they must give (R5)
    localparam vec_t VECS [6] = '{
        '{0,  0,  4,  4},
        '{1,  3,  4,  5},
        '{2,  5,  4,  7},
        '{3,  10, 5,  12},
        '{7,  0,  9,  4},
        '{20, 19, 22, 21}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c0, c1, c2;
        #1 board_rst_n = 1'b0;

        // Reset state, R1
        @(negedge clk);
        @(negedge clk);
        chk("R1 phy held in reset", int'(phy_hold_n), 0);
        chk("R1 stage count in reset", int'(stage_count), 0);
        chk("R1 done in reset", int'(seq_done), 0);

        // Lock low keeps everything held, R1
        board_rst_n = 1'b1;
        clk_locked  = 1'b0;
        repeat (8) @(negedge clk);
        chk("R1 phy held without lock", int'(phy_hold_n), 0);
        chk("R1 link held without lock", int'(link_hold_n), 0);

        // Release latency, R3
        clk_locked = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 phy still held after 3 edges", int'(phy_hold_n), 0);
        @(negedge clk);
        chk("R3 phy released on 4th edge", int'(phy_hold_n), 1);
        chk("R9 count after phy release", int'(stage_count), 1);

        // Vector table, R5 R4 R9 R7
        for (int i = 0; i < 6; i++) begin
            apply_reset();
            wait_hold(0, c0);
            repeat (VECS[i].dp) @(negedge clk);
            phy_ready = 1'b1;
            wait_hold(1, c1);
            chk("R5 phy to link spacing", c1 - c0, VECS[i].g1);
            chk("R4 phy still released", int'(phy_hold_n), 1);
            chk("R9 count after link release", int'(stage_count), 2);
            chk("R9 done before dma", int'(seq_done), 0);
            repeat (VECS[i].dl) @(negedge clk);
            link_ready = 1'b1;
            wait_hold(2, c2);
            chk("R5 link to dma spacing", c2 - c1, VECS[i].g2);
            chk("R9 done with dma", int'(seq_done), 1);
            chk("R9 count complete", int'(stage_count), 3);
            chk("R7 no error when ready in time", int'(timeout_err), 0);
        end

        // Early link ready is ignored, R6
        apply_reset();
        link_ready = 1'b1;
        wait_hold(0, c0);
        repeat (10) @(negedge clk);
        chk("R6 link ready ignored before phy ready", int'(link_hold_n), 0);
        chk("R6 count while waiting on phy", int'(stage_count), 1);
        phy_ready = 1'b1;
        wait_hold(1, c1);
        chk("R6 phy to link spacing", c1 - c0, 12);
        wait_hold(2, c2);
        chk("R6 ready high on entry gives min gap", c2 - c1, GAP);

        // Timeout, R7 R8
        apply_reset();
        wait_hold(0, c0);
        repeat (TMO) @(negedge clk);
        chk("R7 no error one edge before timeout", int'(timeout_err), 0);
        @(negedge clk);
        chk("R7 error on timeout edge", int'(timeout_err), 1);
        chk("R7 link held after timeout", int'(link_hold_n), 0);
        phy_ready = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8 late ready ignored", int'(link_hold_n), 0);
        chk("R8 error sticky", int'(timeout_err), 1);
        chk("R8 count frozen", int'(stage_count), 1);
        #2 board_rst_n = 1'b0;
        #1;
        chk("R2 error cleared by reset without edge", int'(timeout_err), 0);
        chk("R2 phy held without edge", int'(phy_hold_n), 0);

        // Lock loss mid-sequence, R2
        apply_reset();
        phy_ready = 1'b1;
        wait_hold(1, c1);
        @(negedge clk);
        #2 clk_locked = 1'b0;
        #1;
        chk("R2 phy dropped without edge", int'(phy_hold_n), 0);
        chk("R2 link dropped without edge", int'(link_hold_n), 0);
        chk("R2 count cleared without edge", int'(stage_count), 0);
        chk("R2 done low", int'(seq_done), 0);
        @(negedge clk);
        clk_locked = 1'b1;
        repeat (6) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule